// File: doc/BRIEF.md
# Upgrade-Miss Acknowledgement Collector

This block runs the requester side of one write-upgrade at a time. A write upgrade happens when a core writes to a line it holds read-only. The controller takes the line address and a predicted set of nodes that may still hold copies. It sends an invalidate straight to each predicted node and then a read-for-ownership request to the directory. It then gathers invalidation acknowledgements from any node until the directory has named the real sharer set and every member of that set has answered.

Acknowledgements may come from the early, speculative invalidates or from the directory's own invalidates. Each node is therefore counted at most once in a per-node received vector. Every upgrade carries a small wrapping tag, and an acknowledgement whose tag differs from the current one is thrown away. The same applies to any acknowledgement that arrives while no upgrade is open. Once all sharers are covered, a one-cycle grant marks the line as writable. In the following cycle the controller sends an unblock message to the directory.

The block also contains the remote-side rule for answering a speculative invalidate. A node replies, and drops its copy, only when that copy was in the shared state.

Top module: `upg_ack_unit`

## Requirements
- R1: After reset, `start_ready` is 1, `msg_valid` is 0 and `grant` is 0.
- R2: After a start is accepted, one invalidate (kind 0) goes to each predicted node, in ascending node order, one per accepted transfer. A read-for-ownership (kind 1) follows them. Every message carries the start address and the current tag.
- R3: With an empty prediction, the only message before the directory reply is the read-for-ownership.
- R4: While `msg_valid` is 1 and `msg_ready` is 0, the message stays valid and its kind, destination and tag do not change.
- R5: `grant` is a single-cycle pulse. It rises on the second clock edge after the last needed input, and only after the directory reply has arrived and every node in its sharer vector has acknowledged.
- R6: A repeated acknowledgement from a node never counts for another node.
- R7: An acknowledgement whose tag differs from the current upgrade's tag is ignored.
- R8: Acknowledgements that arrive while idle cause no message and no grant.
- R9: The tag is 0 after reset and increases by one for each accepted start, wrapping modulo 2^TAG_W.
- R10: In the cycle after `grant`, an unblock (kind 2) is offered. Once it is accepted, `start_ready` returns to 1.
- R11: A speculative invalidate that meets a shared copy produces an acknowledgement to its sender with the same tag and drops the copy. A speculative invalidate that meets a copy in any other state produces neither.
- R12: A directory reply with an empty sharer vector completes the upgrade with no acknowledgements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_valid | input | 1 | Begin an upgrade |
| start_addr | input | ADDR_W | Line address |
| start_pred | input | NODES | Predicted sharer vector |
| start_ready | output | 1 | Idle, start accepted |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Network accepts message |
| msg_kind | output | 2 | 0 invalidate, 1 read-for-ownership, 2 unblock |
| msg_dest | output | NODE_W | Target node for invalidates, else 0 |
| msg_addr | output | ADDR_W | Line address |
| msg_tag | output | TAG_W | Upgrade tag |
| ack_valid | input | 1 | Acknowledgement arrives |
| ack_src | input | NODE_W | Acknowledging node |
| ack_tag | input | TAG_W | Tag carried by the acknowledgement |
| dir_valid | input | 1 | Directory reply arrives |
| dir_sharers | input | NODES | True sharer vector |
| grant | output | 1 | Write ownership granted (pulse) |
| rinv_valid | input | 1 | Speculative invalidate received by this node |
| rinv_src | input | NODE_W | Its sender |
| rinv_tag | input | TAG_W | Its tag |
| rinv_line_shared | input | 1 | Local copy is in shared state |
| rack_valid | output | 1 | Acknowledgement to send back |
| rack_dest | output | NODE_W | Its destination |
| rack_tag | output | TAG_W | Its tag |
| rinv_drop_line | output | 1 | Invalidate the local copy |

## Verification
The assertions assume that the directory replies only after the read-for-ownership has been accepted, and only once per upgrade. They also assume that `start_valid` is raised only while `start_ready` is 1. The stimulus follows these rules by driving the reply after the read-for-ownership transfer and one start per finished upgrade. It sweeps every 8-bit prediction with a derived sharer set. Stale, duplicate and idle acknowledgements are injected only at points where an early grant would become visible at the port.

// File: rtl/upg_pkg.sv
package upg_pkg;
  typedef enum logic [1:0] {
    MSG_INV   = 2'd0,
    MSG_RDX   = 2'd1,
    MSG_UNBLK = 2'd2
  } msg_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GRANT,
    ST_UNBLK
  } upg_state_e;
endpackage

// File: rtl/upg_msg_issuer.sv
module upg_msg_issuer #(
  parameter int NODES = 8,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NODES-1:0]  load_vec,
  input  logic              issue_en,
  input  logic              msg_ready,
  output logic              inv_pending,
  output logic [NODE_W-1:0] inv_dest
);
  logic [NODES-1:0] pend_q, pend_d;

  always_comb begin
    inv_dest = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend_q[i]) inv_dest = NODE_W'(i);
    end
  end

  assign inv_pending = |pend_q;

  always_comb begin
    pend_d = pend_q;
    if (load) begin
      pend_d = load_vec;
    end else if (issue_en && msg_ready && inv_pending) begin
      for (int i = 0; i < NODES; i++) begin
        if (inv_dest == NODE_W'(i)) pend_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/upg_ack_tracker.sv
module upg_ack_tracker #(
  parameter int NODES = 8,
  parameter int TAG_W = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              collect,
  input  logic              dir_open,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic              ack_valid,
  input  logic [NODE_W-1:0] ack_src,
  input  logic [TAG_W-1:0]  ack_tag,
  input  logic              dir_valid,
  input  logic [NODES-1:0]  dir_sharers,
  output logic              dir_seen,
  output logic              covered
);
  logic [NODES-1:0] rcvd_q, rcvd_d, true_q, true_d;
  logic             seen_q, seen_d;
  logic             ack_hit;

  assign ack_hit = collect && ack_valid && (ack_tag == cur_tag);

  always_comb begin
    rcvd_d = rcvd_q;
    true_d = true_q;
    seen_d = seen_q;
    if (clear) begin
      rcvd_d = '0;
      true_d = '0;
      seen_d = 1'b0;
    end else begin
      for (int i = 0; i < NODES; i++) begin
        if (ack_hit && ack_src == NODE_W'(i)) rcvd_d[i] = 1'b1;
      end
      if (dir_open && dir_valid) begin
        true_d = dir_sharers;
        seen_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcvd_q <= '0;
      true_q <= '0;
      seen_q <= 1'b0;
    end else begin
      rcvd_q <= rcvd_d;
      true_q <= true_d;
      seen_q <= seen_d;
    end
  end

  assign dir_seen = seen_q;
  assign covered  = ((rcvd_q & true_q) == true_q);

  // Received bits never fall except on a new upgrade.
  assert_ack_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((rcvd_q | $past(rcvd_q)) == rcvd_q));
endmodule

// File: rtl/upg_remote_inv.sv
module upg_remote_inv #(
  parameter int NODES = 8,
  parameter int TAG_W = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              rinv_valid,
  input  logic [NODE_W-1:0] rinv_src,
  input  logic [TAG_W-1:0]  rinv_tag,
  input  logic              rinv_line_shared,
  output logic              rack_valid,
  output logic [NODE_W-1:0] rack_dest,
  output logic [TAG_W-1:0]  rack_tag,
  output logic              rinv_drop_line
);
  logic answer;
  assign answer         = rinv_valid && rinv_line_shared;
  assign rack_valid     = answer;
  assign rinv_drop_line = answer;
  assign rack_dest      = rinv_src;
  assign rack_tag       = rinv_tag;
endmodule

// File: rtl/upg_ack_unit.sv
module upg_ack_unit import upg_pkg::*; #(
  parameter int NODES  = 8,
  parameter int ADDR_W = 16,
  parameter int TAG_W  = 4,
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [NODES-1:0]  start_pred,
  output logic              start_ready,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [1:0]        msg_kind,
  output logic [NODE_W-1:0] msg_dest,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [TAG_W-1:0]  msg_tag,
  input  logic              ack_valid,
  input  logic [NODE_W-1:0] ack_src,
  input  logic [TAG_W-1:0]  ack_tag,
  input  logic              dir_valid,
  input  logic [NODES-1:0]  dir_sharers,
  output logic              grant,
  input  logic              rinv_valid,
  input  logic [NODE_W-1:0] rinv_src,
  input  logic [TAG_W-1:0]  rinv_tag,
  input  logic              rinv_line_shared,
  output logic              rack_valid,
  output logic [NODE_W-1:0] rack_dest,
  output logic [TAG_W-1:0]  rack_tag,
  output logic              rinv_drop_line
);
  upg_state_e        state_q, state_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              start_fire, inv_pending, dir_seen, covered;
  logic [NODE_W-1:0] inv_dest;

  assign start_ready = (state_q == ST_IDLE);
  assign start_fire  = start_valid && start_ready;

  upg_msg_issuer #(.NODES(NODES)) u_issuer (
    .clk(clk), .rst_n(rst_n), .load(start_fire), .load_vec(start_pred),
    .issue_en(state_q == ST_ISSUE), .msg_ready(msg_ready),
    .inv_pending(inv_pending), .inv_dest(inv_dest)
  );

  upg_ack_tracker #(.NODES(NODES), .TAG_W(TAG_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .clear(start_fire),
    .collect(state_q == ST_ISSUE || state_q == ST_WAIT),
    .dir_open(state_q == ST_WAIT), .cur_tag(tag_q),
    .ack_valid(ack_valid), .ack_src(ack_src), .ack_tag(ack_tag),
    .dir_valid(dir_valid), .dir_sharers(dir_sharers),
    .dir_seen(dir_seen), .covered(covered)
  );

  upg_remote_inv #(.NODES(NODES), .TAG_W(TAG_W)) u_remote (
    .rinv_valid(rinv_valid), .rinv_src(rinv_src), .rinv_tag(rinv_tag),
    .rinv_line_shared(rinv_line_shared), .rack_valid(rack_valid),
    .rack_dest(rack_dest), .rack_tag(rack_tag), .rinv_drop_line(rinv_drop_line)
  );

  always_comb begin
    state_d = state_q;
    tag_d   = tag_q;
    addr_d  = addr_q;
    case (state_q)
      ST_IDLE: if (start_fire) begin
        state_d = ST_ISSUE;
        tag_d   = tag_q + 1'b1;
        addr_d  = start_addr;
      end
      ST_ISSUE: if (msg_ready && !inv_pending) state_d = ST_WAIT;
      ST_WAIT:  if (dir_seen && covered) state_d = ST_GRANT;
      ST_GRANT: state_d = ST_UNBLK;
      ST_UNBLK: if (msg_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      tag_q   <= tag_d;
      addr_q  <= addr_d;
    end
  end

  always_comb begin
    msg_valid = (state_q == ST_ISSUE) || (state_q == ST_UNBLK);
    msg_kind  = MSG_UNBLK;
    msg_dest  = '0;
    if (state_q == ST_ISSUE) begin
      msg_kind = inv_pending ? MSG_INV : MSG_RDX;
      msg_dest = inv_pending ? inv_dest : '0;
    end
  end

  assign msg_addr = addr_q;
  assign msg_tag  = tag_q;
  assign grant    = (state_q == ST_GRANT);

  assert_msg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) &&
                                   $stable(msg_dest) && $stable(msg_tag)));
  assert_grant_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  assert_grant_covered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (dir_seen && covered));
  assert_unblock_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (msg_valid && msg_kind == MSG_UNBLK));
endmodule

// File: tb/upg_ack_unit_test.sv
module upg_ack_unit_test;
  localparam int NODES = 8, ADDR_W = 16, TAG_W = 4, NODE_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, msg_ready = 1'b0, ack_valid = 1'b0, dir_valid = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [NODES-1:0]  start_pred = '0, dir_sharers = '0;
  logic [NODE_W-1:0] ack_src = '0, rinv_src = '0;
  logic [TAG_W-1:0]  ack_tag = '0, rinv_tag = '0;
  logic rinv_valid = 1'b0, rinv_line_shared = 1'b0;
  logic start_ready, msg_valid, grant, rack_valid, rinv_drop_line;
  logic [1:0] msg_kind;
  logic [NODE_W-1:0] msg_dest, rack_dest;
  logic [ADDR_W-1:0] msg_addr;
  logic [TAG_W-1:0]  msg_tag, rack_tag;

  int checks = 0, fails = 0, cycles = 0;
  logic [TAG_W-1:0] exp_tag = '0;

  always #5 clk = ~clk;

  upg_ack_unit #(.NODES(NODES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_addr(start_addr),
    .start_pred(start_pred), .start_ready(start_ready), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_kind(msg_kind), .msg_dest(msg_dest),
    .msg_addr(msg_addr), .msg_tag(msg_tag), .ack_valid(ack_valid),
    .ack_src(ack_src), .ack_tag(ack_tag), .dir_valid(dir_valid),
    .dir_sharers(dir_sharers), .grant(grant), .rinv_valid(rinv_valid),
    .rinv_src(rinv_src), .rinv_tag(rinv_tag), .rinv_line_shared(rinv_line_shared),
    .rack_valid(rack_valid), .rack_dest(rack_dest), .rack_tag(rack_tag),
    .rinv_drop_line(rinv_drop_line)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_ack(int src, logic [TAG_W-1:0] tg);
    ack_valid = 1'b1; ack_src = NODE_W'(src); ack_tag = tg;
    tick();
    ack_valid = 1'b0;
  endtask

  task automatic run_txn(logic [NODES-1:0] p, logic [NODES-1:0] s, bit stall);
    int first_s, last_s;
    first_s = -1; last_s = -1;
    for (int i = 0; i < NODES; i++) if (s[i]) begin
      if (first_s < 0) first_s = i;
      last_s = i;
    end
    msg_ready = 1'b0;
    start_valid = 1'b1; start_pred = p; start_addr = ADDR_W'(16'hA000 + p);
    tick();
    start_valid = 1'b0;
    exp_tag = exp_tag + 1'b1;
    if (stall) begin
      for (int k = 0; k < 3; k++) begin
        chk("R4 stalled valid", msg_valid, 1);
        chk("R4 stalled kind", msg_kind, (p != 0) ? 0 : 1);
        tick();
      end
    end
    msg_ready = 1'b1;
    for (int i = 0; i < NODES; i++) if (p[i]) begin
      chk("R2 inv valid", msg_valid, 1);
      chk("R2 inv kind", msg_kind, 0);
      chk("R2 inv dest", msg_dest, i);
      chk("R2 inv addr", msg_addr, 16'hA000 + p);
      chk("R9 inv tag", msg_tag, exp_tag);
      tick();
    end
    chk(p == 0 ? "R3 rdx only" : "R2 rdx after invs", msg_kind, 1);
    chk("R2 rdx valid", msg_valid, 1);
    chk("R9 rdx tag", msg_tag, exp_tag);
    tick();
    msg_ready = 1'b0;
    chk("R2 quiet after rdx", msg_valid, 0);
    for (int i = 0; i < NODES; i++) if (s[i] && i != last_s) begin
      send_ack(i, exp_tag);
      tick();
      chk("R5 no grant before dir", grant, 0);
    end
    if (s != 0) begin
      dir_valid = 1'b1; dir_sharers = s;
      tick();
      dir_valid = 1'b0;
      tick();
      chk("R5 no grant with ack missing", grant, 0);
      send_ack(last_s, exp_tag + 1'b1);
      tick();
      chk("R7 stale ack ignored", grant, 0);
      if (first_s != last_s) begin
        send_ack(first_s, exp_tag);
        tick();
        chk("R6 duplicate ack ignored", grant, 0);
      end
      send_ack(last_s, exp_tag);
    end else begin
      dir_valid = 1'b1; dir_sharers = s;
      tick();
      dir_valid = 1'b0;
    end
    chk("R5 grant not yet", grant, 0);
    tick();
    chk(s == 0 ? "R12 grant without acks" : "R5 grant", grant, 1);
    chk("R5 no msg while grant", msg_valid, 0);
    msg_ready = 1'b1;
    tick();
    chk("R5 grant pulse", grant, 0);
    chk("R10 unblock valid", msg_valid, 1);
    chk("R10 unblock kind", msg_kind, 2);
    tick();
    chk("R10 back to ready", start_ready, 1);
    msg_ready = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk);
    chk("R1 ready in reset", start_ready, 1);
    tick();
    rst_n = 1'b1;
    tick();
    chk("R1 start_ready", start_ready, 1);
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 grant", grant, 0);

    for (int sh = 0; sh < 2; sh++) for (int src = 0; src < NODES; src++) begin
      rinv_valid = 1'b1; rinv_src = NODE_W'(src); rinv_tag = TAG_W'(src + 3);
      rinv_line_shared = sh[0];
      #1;
      chk("R11 ack only if shared", rack_valid, sh);
      chk("R11 drop only if shared", rinv_drop_line, sh);
      if (sh == 1) begin
        chk("R11 ack dest", rack_dest, src);
        chk("R11 ack tag", rack_tag, (src + 3) % 16);
      end
    end
    rinv_valid = 1'b0;
    #1;
    chk("R11 idle no ack", rack_valid, 0);

    for (int k = 0; k < 3; k++) begin
      send_ack(k, '0);
      tick();
      chk("R8 idle ack no grant", grant, 0);
      chk("R8 idle ack no msg", msg_valid, 0);
      chk("R8 still ready", start_ready, 1);
    end

    for (int p = 0; p < 256; p++) begin
      logic [7:0] pv;
      pv = 8'(p);
      run_txn(pv, pv ^ {pv[6:0], pv[7]}, (p % 37) == 5);
    end
    run_txn(8'h81, 8'h00, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule